// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. A tester drives four wires (test clock, mode select, data in and an optional test reset) and reads one data-out wire. A sixteen-state controller walks through the standard capture, shift and update phases. A three-bit instruction register chooses which data register sits between the serial input and output, and which test controls reach the rest of the chip.

Four data registers can be placed on the serial path: a one-stage bypass, a 32-bit identification word, a one-bit memory self-test status, and a boundary register whose length is a parameter. Besides the serial path the block drives a one-cycle self-test start pulse, an internal scan test-mode flag that is used to hold off asynchronous resets, a flag that floats every functional output, and a select that makes the outputs follow the boundary register. The pad cells, the memory self-test engine and the scan chains are outside the block and appear only as ports.

Top module: `tap_controller`

## Requirements
- R1: A high `trst` sampled on a rising `tck`, or a pass through Test-Logic-Reset, loads IDCODE (010) into the instruction register. The identification word then shifts out LSB first: bit 0 = 1, bits 11:1 = 0x00F, bits 27:12 = 0xFC17, bits 31:28 = 0x0.
- R2: Five rising `tck` edges with `tms` high reach Test-Logic-Reset from any state, and IDCODE is then the instruction.
- R3: Instruction codes are EXTEST 000, SAMPLE/PRELOAD 001, IDCODE 010, HIGHZ 011, CLAMP 100, SCANTEST 101, RUNBIST 110 and BYPASS 111. Capture-IR loads 001, which shifts out LSB first. A shifted code takes effect only when the controller leaves Update-IR.
- R4: BYPASS places one stage, captured as 0, between `tdi` and `tdo`.
- R5: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R6: SAMPLE/PRELOAD captures `pins_in` into the boundary register in Capture-DR. The register shifts LSB first, so bit i is the i-th bit out and the i-th bit in. Update-DR copies it to `bsr_out`, and `bsr_drive` stays low.
- R7: EXTEST captures and updates the boundary register as in R6, and it raises `bsr_drive`.
- R8: CLAMP raises `bsr_drive` and selects the bypass path. `bsr_out` keeps its value through DR scans.
- R9: HIGHZ raises `out_hiz` and selects the bypass path.
- R10: Loading RUNBIST gives exactly one high cycle of `bist_start`, in the cycle after Update-IR. It also selects a one-bit status register that captures `bist_done & bist_pass`.
- R11: SCANTEST raises `test_mode` and selects the bypass path. It produces no `bist_start` pulse.
- R12: At most one of `test_mode`, `out_hiz` and `bsr_drive` is high at a time. All three are low under IDCODE, BYPASS, SAMPLE/PRELOAD and RUNBIST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| pins_in | input | BSR_LEN | Pin values captured by the boundary register |
| bsr_out | output | BSR_LEN | Boundary update stage, drives pins in EXTEST/CLAMP |
| bist_done | input | 1 | Memory self-test finished |
| bist_pass | input | 1 | Memory self-test found no fault |
| bist_start | output | 1 | One-cycle self-test start pulse |
| test_mode | output | 1 | Internal scan mode, blocks asynchronous resets |
| out_hiz | output | 1 | Float all functional outputs |
| bsr_drive | output | 1 | Outputs follow `bsr_out` |

## Verification
The bench targets the exact length of each serial path. A one-stage mismatch in bypass, or a wrong field order in the identification word, shows up as a bit-shifted word. It checks that CLAMP leaves the boundary update stage untouched, because a design that updated on every Update-DR would overwrite the clamped pin values. It also counts start pulses, since a self-test start tied to the instruction level rather than to the update edge would repeat or never end. It drives reset both through `trst` and through five TMS-high clocks, because a controller that misses either route would keep a stale instruction such as SCANTEST and leave asynchronous resets blocked.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [IR_W-1:0] {
        I_EXTEST   = 3'b000,
        I_SAMPLE   = 3'b001,
        I_IDCODE   = 3'b010,
        I_HIGHZ    = 3'b011,
        I_CLAMP    = 3'b100,
        I_SCANTEST = 3'b101,
        I_RUNBIST  = 3'b110,
        I_BYPASS   = 3'b111
    } instr_e;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_ID, DR_BIST, DR_BOUND
    } dr_sel_e;

    typedef struct packed {
        logic test_mode;
        logic out_hiz;
        logic bsr_drive;
    } ctl_t;

    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic tap_state_e next_state(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TLR:     n = m ? TLR    : RTI;
            RTI:     n = m ? SEL_DR : RTI;
            SEL_DR:  n = m ? SEL_IR : CAP_DR;
            CAP_DR:  n = m ? EX1_DR : SH_DR;
            SH_DR:   n = m ? EX1_DR : SH_DR;
            EX1_DR:  n = m ? UPD_DR : PAU_DR;
            PAU_DR:  n = m ? EX2_DR : PAU_DR;
            EX2_DR:  n = m ? UPD_DR : SH_DR;
            UPD_DR:  n = m ? SEL_DR : RTI;
            SEL_IR:  n = m ? TLR    : CAP_IR;
            CAP_IR:  n = m ? EX1_IR : SH_IR;
            SH_IR:   n = m ? EX1_IR : SH_IR;
            EX1_IR:  n = m ? UPD_IR : PAU_IR;
            PAU_IR:  n = m ? EX2_IR : PAU_IR;
            EX2_IR:  n = m ? UPD_IR : SH_IR;
            UPD_IR:  n = m ? SEL_DR : RTI;
            default: n = TLR;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e dr_select(input instr_e i);
        dr_sel_e d;
        case (i)
            I_EXTEST, I_SAMPLE: d = DR_BOUND;
            I_IDCODE:           d = DR_ID;
            I_RUNBIST:          d = DR_BIST;
            default:            d = DR_BYPASS;
        endcase
        return d;
    endfunction

    function automatic ctl_t ctl_decode(input instr_e i);
        ctl_t c;
        c.test_mode = (i == I_SCANTEST);
        c.out_hiz   = (i == I_HIGHZ);
        c.bsr_drive = (i == I_EXTEST) || (i == I_CLAMP);
        return c;
    endfunction

    function automatic logic [ID_W-1:0] id_word(input logic [3:0] ver,
                                                input logic [15:0] part,
                                                input logic [10:0] mfr);
        return {ver, part, mfr, 1'b1};
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (trst) state <= TLR;
        else      state <= next_state(state, tms);
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst,
    input  logic       tdi,
    input  tap_state_e state,
    output instr_e     ir,
    output logic       ir_lsb,
    output logic       bist_go
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck) begin
        if (trst) begin
            ir_sr   <= IR_CAPTURE;
            ir      <= I_IDCODE;
            bist_go <= 1'b0;
        end else begin
            bist_go <= (state == UPD_IR) && (ir_sr == I_RUNBIST);
            case (state)
                TLR:     ir    <= I_IDCODE;
                CAP_IR:  ir_sr <= IR_CAPTURE;
                SH_IR:   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                UPD_IR:  ir    <= instr_e'(ir_sr);
                default: ;
            endcase
        end
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int               BSR_LEN  = 35,
    parameter logic [ID_W-1:0]  ID_VALUE = '0
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               tdi,
    input  tap_state_e         state,
    input  instr_e             ir,
    input  logic [BSR_LEN-1:0] pins_in,
    input  logic               bist_done,
    input  logic               bist_pass,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_out
);

    dr_sel_e            sel;
    logic               byp_q;
    logic               bist_q;
    logic [ID_W-1:0]    id_sr;
    logic [BSR_LEN-1:0] bsr_sr;
    logic [BSR_LEN-1:0] bsr_next;
    logic               upd_ok;

    assign sel    = dr_select(ir);
    assign upd_ok = (ir == I_EXTEST) || (ir == I_SAMPLE);

    generate
        if (BSR_LEN == 1) begin : g_bsr_one
            assign bsr_next = tdi;
        end else begin : g_bsr_many
            assign bsr_next = {tdi, bsr_sr[BSR_LEN-1:1]};
        end
    endgenerate

    always_ff @(posedge tck) begin
        if (trst) begin
            byp_q   <= 1'b0;
            bist_q  <= 1'b0;
            id_sr   <= '0;
            bsr_sr  <= '0;
            bsr_out <= '0;
        end else begin
            if (state == CAP_DR) begin
                case (sel)
                    DR_BYPASS: byp_q  <= 1'b0;
                    DR_ID:     id_sr  <= ID_VALUE;
                    DR_BIST:   bist_q <= bist_done & bist_pass;
                    DR_BOUND:  bsr_sr <= pins_in;
                    default:   ;
                endcase
            end
            if (state == SH_DR) begin
                case (sel)
                    DR_BYPASS: byp_q  <= tdi;
                    DR_ID:     id_sr  <= {tdi, id_sr[ID_W-1:1]};
                    DR_BIST:   bist_q <= tdi;
                    DR_BOUND:  bsr_sr <= bsr_next;
                    default:   ;
                endcase
            end
            if (state == UPD_DR && upd_ok) bsr_out <= bsr_sr;
        end
    end

    always_comb begin
        case (sel)
            DR_ID:    dr_lsb = id_sr[0];
            DR_BIST:  dr_lsb = bist_q;
            DR_BOUND: dr_lsb = bsr_sr[0];
            default:  dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_controller.sv
module tap_controller
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 35,
    parameter logic [3:0]  ID_VER  = 4'h0,
    parameter logic [15:0] ID_PART = 16'hFC17,
    parameter logic [10:0] ID_MFR  = 11'h00F
) (
    input  logic               tck,
    input  logic               trst,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic [BSR_LEN-1:0] bsr_out,
    input  logic               bist_done,
    input  logic               bist_pass,
    output logic               bist_start,
    output logic               test_mode,
    output logic               out_hiz,
    output logic               bsr_drive
);

    localparam logic [ID_W-1:0] ID_VALUE = id_word(ID_VER, ID_PART, ID_MFR);

    tap_state_e st;
    instr_e     ir_q;
    logic       ir_lsb;
    logic       dr_lsb;
    ctl_t       ctl;

    tap_fsm u_fsm (
        .tck   (tck),
        .trst  (trst),
        .tms   (tms),
        .state (st)
    );

    tap_ir u_ir (
        .tck     (tck),
        .trst    (trst),
        .tdi     (tdi),
        .state   (st),
        .ir      (ir_q),
        .ir_lsb  (ir_lsb),
        .bist_go (bist_start)
    );

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck       (tck),
        .trst      (trst),
        .tdi       (tdi),
        .state     (st),
        .ir        (ir_q),
        .pins_in   (pins_in),
        .bist_done (bist_done),
        .bist_pass (bist_pass),
        .dr_lsb    (dr_lsb),
        .bsr_out   (bsr_out)
    );

    // serial output launched on the falling edge, half a cycle before capture
    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (st == SH_IR) || (st == SH_DR);
            tdo    <= (st == SH_IR) ? ir_lsb : dr_lsb;
        end
    end

    assign ctl       = ctl_decode(ir_q);
    assign test_mode = ctl.test_mode;
    assign out_hiz   = ctl.out_hiz;
    assign bsr_drive = ctl.bsr_drive;

endmodule

// File: rtl/tap_checker.sv
module tap_checker
    import tap_pkg::*;
#(
    parameter int BSR_LEN = 35
) (
    input logic               tck,
    input logic               trst,
    input tap_state_e         state,
    input instr_e             ir,
    input logic               tdo_oe,
    input logic               bist_start,
    input logic               test_mode,
    input logic               out_hiz,
    input logic               bsr_drive,
    input logic [BSR_LEN-1:0] bsr_out
);

    // R5: output enable only while shifting
    a_r5_oe_in_shift: assert property (@(posedge tck) disable iff (trst)
        tdo_oe |-> (state == SH_IR || state == SH_DR));

    // R1: reset state forces IDCODE
    a_r1_tlr_idcode: assert property (@(posedge tck) disable iff (trst)
        (state == TLR) |=> (ir == I_IDCODE));

    // R3: instruction moves only from Update-IR or Test-Logic-Reset
    a_r3_ir_on_update: assert property (@(posedge tck) disable iff (trst)
        !$stable(ir) |-> ($past(state) == UPD_IR || $past(state) == TLR));

    // R10: start pulse lasts one cycle and follows Update-IR
    a_r10_pulse_single: assert property (@(posedge tck) disable iff (trst)
        bist_start |=> !bist_start);

    a_r10_pulse_after_upd: assert property (@(posedge tck) disable iff (trst)
        $rose(bist_start) |-> ($past(state) == UPD_IR));

    // R12: test controls never overlap
    a_r12_ctl_onehot: assert property (@(posedge tck) disable iff (trst)
        $onehot0({test_mode, out_hiz, bsr_drive}));

    // R8: clamped pins hold while CLAMP stays loaded
    a_r8_clamp_hold: assert property (@(posedge tck) disable iff (trst)
        (ir == I_CLAMP && $past(ir) == I_CLAMP) |-> $stable(bsr_out));

endmodule

bind tap_controller tap_checker #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck        (tck),
    .trst       (trst),
    .state      (st),
    .ir         (ir_q),
    .tdo_oe     (tdo_oe),
    .bist_start (bist_start),
    .test_mode  (test_mode),
    .out_hiz    (out_hiz),
    .bsr_drive  (bsr_drive),
    .bsr_out    (bsr_out)
);

// File: tb/tb_tap_controller.sv
module tb_tap_controller;

    localparam int BL = 35;
    localparam logic [63:0] BMASK = (64'd1 << BL) - 64'd1;
    localparam logic [31:0] EXP_ID = {4'h0, 16'hFC17, 11'h00F, 1'b1};

    logic          tck = 1'b0;
    logic          trst = 1'b1;
    logic          tms = 1'b1;
    logic          tdi = 1'b0;
    logic          tdo, tdo_oe;
    logic [BL-1:0] pins_in = '0;
    logic [BL-1:0] bsr_out;
    logic          bist_done = 1'b0;
    logic          bist_pass = 1'b0;
    logic          bist_start, test_mode, out_hiz, bsr_drive;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #4 tck = ~tck;

    tap_controller #(.BSR_LEN(BL)) dut (
        .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .pins_in(pins_in), .bsr_out(bsr_out), .bist_done(bist_done),
        .bist_pass(bist_pass), .bist_start(bist_start), .test_mode(test_mode),
        .out_hiz(out_hiz), .bsr_drive(bsr_drive)
    );

    always @(negedge tck) if (bist_start === 1'b1) pulses++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge tck);
        #1;
    endtask

    task automatic step(input logic m, input logic d, input logic exp_oe, output logic q);
        settle();
        q = tdo;
        chk("R5 tdo_oe", {63'd0, tdo_oe}, {63'd0, exp_oe});
        tms = m;
        tdi = d;
        @(posedge tck);
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        logic q;
        step(1, 0, 0, q);
        step(1, 0, 0, q);
        step(0, 0, 0, q);
        step(0, 0, 0, q);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, code[i], 1, q);
            cap[i] = q;
        end
        step(1, 0, 0, q);
        step(0, 0, 0, q);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
        logic q;
        dout = '0;
        step(1, 0, 0, q);
        step(0, 0, 0, q);
        step(0, 0, 0, q);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], 1, q);
            dout[i] = q;
        end
        step(1, 0, 0, q);
        step(0, 0, 0, q);
    endtask

    task automatic do_reset();
        logic q;
        trst = 1'b1;
        tms  = 1'b1;
        repeat (3) @(posedge tck);
        settle();
        trst = 1'b0;
        step(0, 0, 0, q);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        do_reset();
        settle();
        chk("R12 controls after reset", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd0);
        chk("R1 bsr_out after reset", {29'd0, bsr_out}, 64'd0);
        chk("R5 tdo_oe idle", {63'd0, tdo_oe}, 64'd0);
        scan_dr(32, 64'd0, d);
        chk("R1 id word", d, {32'd0, EXP_ID});
    endtask

    task automatic t_capture_ir();
        logic [2:0] c;
        logic [63:0] d;
        scan_ir(3'b111, c);
        chk("R3 capture-ir pattern", {61'd0, c}, 64'd1);
        scan_dr(8, 64'hB2, d);
        chk("R4 bypass one stage", d, {56'd0, 8'h64});
    endtask

    task automatic t_tlr_via_tms();
        logic q;
        logic [2:0] c;
        logic [63:0] d;
        scan_ir(3'b101, c);
        settle();
        chk("R11 test_mode set", {63'd0, test_mode}, 64'd1);
        for (int i = 0; i < 5; i++) step(1, 0, 0, q);
        step(0, 0, 0, q);
        settle();
        chk("R2 test_mode cleared by tms", {63'd0, test_mode}, 64'd0);
        scan_dr(32, 64'd0, d);
        chk("R2 idcode restored", d, {32'd0, EXP_ID});
    endtask

    task automatic t_sample();
        logic [2:0] c;
        logic [63:0] d;
        logic [63:0] pat;
        pat = 64'h3_1234_5678 & BMASK;
        pins_in = BL'(64'h5_A5A5_C3C3 & BMASK);
        scan_ir(3'b001, c);
        settle();
        chk("R12 sample controls low", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd0);
        scan_dr(BL, pat, d);
        chk("R6 sample capture", d, 64'h5_A5A5_C3C3 & BMASK);
        settle();
        chk("R6 preload update", {29'd0, bsr_out}, pat);
    endtask

    task automatic t_extest();
        logic [2:0] c;
        logic [63:0] d;
        logic [63:0] pat;
        pat = 64'h6_0F0F_9999 & BMASK;
        pins_in = BL'(64'h1_2222_4444 & BMASK);
        scan_ir(3'b000, c);
        settle();
        chk("R7 extest drive", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd1);
        scan_dr(BL, pat, d);
        chk("R7 extest capture", d, 64'h1_2222_4444 & BMASK);
        settle();
        chk("R7 extest update", {29'd0, bsr_out}, pat);
    endtask

    task automatic t_clamp();
        logic [2:0] c;
        logic [63:0] d;
        logic [63:0] held;
        held = {29'd0, bsr_out};
        scan_ir(3'b100, c);
        settle();
        chk("R8 clamp drive", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd1);
        scan_dr(2, 64'h3, d);
        chk("R8 clamp bypass path", d, 64'h2);
        settle();
        chk("R8 clamp holds bsr_out", {29'd0, bsr_out}, held);
    endtask

    task automatic t_highz();
        logic [2:0] c;
        logic [63:0] d;
        scan_ir(3'b011, c);
        settle();
        chk("R9 highz flag", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd2);
        scan_dr(3, 64'h5, d);
        chk("R9 highz bypass path", d, 64'h2);
    endtask

    task automatic t_runbist();
        logic [2:0] c;
        logic [63:0] d;
        int p0;
        bist_done = 1'b1;
        bist_pass = 1'b1;
        p0 = pulses;
        scan_ir(3'b110, c);
        settle();
        chk("R10 one start pulse", 64'(pulses - p0), 64'd1);
        chk("R12 runbist controls low", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd0);
        scan_dr(2, 64'h0, d);
        chk("R10 status pass", d, 64'h1);
        bist_pass = 1'b0;
        scan_dr(2, 64'h0, d);
        chk("R10 status fail", d, 64'h0);
        bist_pass = 1'b1;
        bist_done = 1'b0;
        scan_dr(2, 64'h0, d);
        chk("R10 status not done", d, 64'h0);
        chk("R10 no repeat pulse", 64'(pulses - p0), 64'd1);
    endtask

    task automatic t_scantest_trst();
        logic [2:0] c;
        logic [63:0] d;
        int p0;
        p0 = pulses;
        scan_ir(3'b101, c);
        settle();
        chk("R11 test_mode", {61'd0, test_mode, out_hiz, bsr_drive}, 64'd4);
        chk("R11 no start pulse", 64'(pulses - p0), 64'd0);
        scan_dr(2, 64'h1, d);
        chk("R11 bypass path", d, 64'h2);
        do_reset();
        settle();
        chk("R1 trst clears test_mode", {63'd0, test_mode}, 64'd0);
        scan_dr(32, 64'd0, d);
        chk("R1 idcode after trst", d, {32'd0, EXP_ID});
    endtask

    initial begin
        t_reset();
        t_capture_ir();
        t_tlr_via_tms();
        t_sample();
        t_extest();
        t_clamp();
        t_highz();
        t_runbist();
        t_scantest_trst();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge tck);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule